// File: doc/BRIEF.md
# Energy-Efficient Ethernet Low-Power-Idle Control and Status Register

This block is the software-visible control and status word for the low-power-idle (LPI) feature of an Ethernet MAC, and it also watches the GMII receive path for the LPI pattern. Software writes four control fields through a simple register port: automatic mode, link-status source select, link status, and the LPI enable request. It reads back those fields together with live transmit and receive LPI status and four sticky event flags. The event flags record transmit entry, transmit exit, receive entry and receive exit. A read returns the flags and then clears them.

The transmit LPI controller sits outside this block. It supplies single-cycle pulses for its entry and exit events, a pulse for an automatic exit that withdraws the enable request, and a level that shows when it is sending LPI. The block finds receive LPI itself. A cycle carries the pattern when data-valid is low, error is high and the receive byte equals the LPI code. A run of the pattern must last the configured number of consecutive cycles before it counts as entry, so short bursts are ignored.

Top module: `lpi_ctl_stat_reg`

## Requirements
- R1: After a synchronous reset every field of the 32-bit word reads 0, and the four control output ports are 0.
- R2: A write loads the control fields from the write data: bit 19 automatic mode, bit 18 link-status source select, bit 17 link status, bit 16 LPI enable. A later read returns them, and the control output ports show them from the cycle after the write. Bits 31..20, 15..10 and 7..4 always read 0.
- R3: Writes have no effect on the read-only bits: 9 (receive live), 8 (transmit live) and 3..0 (event flags).
- R4: A transmit entry pulse sets bit 0 and a transmit exit pulse sets bit 1. Each bit stays set until it is read.
- R5: A read strobe returns the word on rd_data in the next cycle, holds it there, and clears bits 3..0 at the same clock edge.
- R6: When an event pulse and a read strobe fall in the same cycle, the read returns the value the bit had before that edge, and the bit is set afterwards.
- R7: An automatic-exit pulse clears bit 16 and leaves bits 19..17 unchanged.
- R8: When a write and an automatic-exit pulse fall in the same cycle, bit 16 ends at 0 and bits 19..17 take the written values.
- R9: Bit 8 shows the transmit-LPI-active input delayed by one clock.
- R10: A receive cycle is an LPI cycle only when rx_dv=0, rx_er=1 and rxd=0x01. Any other combination breaks a run.
- R11: At the third consecutive LPI receive cycle the block enters receive LPI: bit 9 rises and bit 2 is set, both at the same edge.
- R12: A run of LPI receive cycles shorter than three cycles changes neither bit 9 nor bits 2 and 3.
- R13: While in receive LPI, the first non-LPI receive cycle clears bit 9 and sets bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; also clears the event flags |
| rd_data | output | 32 | Registered read data |
| rx_dv | input | 1 | GMII receive data valid |
| rx_er | input | 1 | GMII receive error |
| rxd | input | 8 | GMII receive data |
| tx_enter_pulse | input | 1 | Transmit controller entered LPI |
| tx_exit_pulse | input | 1 | Transmit controller left LPI |
| tx_auto_exit | input | 1 | Automatic exit; clears the enable field |
| tx_lpi_active | input | 1 | Transmit controller is sending LPI |
| ctl_auto_mode | output | 1 | Automatic mode field |
| ctl_link_sel | output | 1 | Link-status source select field |
| ctl_link_up | output | 1 | Link status field |
| ctl_lpi_en | output | 1 | LPI enable field |

## Verification
The receive detector is driven with every pairing of data-valid and error combined with several receive bytes: the LPI code, zero, a neighbouring code and all-ones. Only the exact code with valid low and error high may count as entry. Runs of the correct pattern from one to six cycles long, and two short runs split by a one-cycle gap, separate the filter length from plain run counting. Two reads in a row after each run show entry and exit apart. The control fields are swept over all sixteen values while every other bit is written as one, which tests both the fields and the read-only and reserved bits. A read placed on the same edge as an event pulse, with the flag first set and then clear, shows the read-before-clear ordering.

// File: rtl/lpi_csr_pkg.sv
package lpi_csr_pkg;

  localparam int WORD_W = 32;

  localparam int POS_AUTO    = 19;
  localparam int POS_LSSEL   = 18;
  localparam int POS_LINK    = 17;
  localparam int POS_EN      = 16;
  localparam int POS_RX_LIVE = 9;
  localparam int POS_TX_LIVE = 8;

  localparam int NUM_EVT = 4;
  localparam int EVT_TX_ENTER = 0;
  localparam int EVT_TX_EXIT  = 1;
  localparam int EVT_RX_ENTER = 2;
  localparam int EVT_RX_EXIT  = 3;

  typedef struct packed {
    logic auto_mode;
    logic link_sel;
    logic link_up;
    logic lpi_en;
  } ctl_fields_t;

  localparam int CTL_W = $bits(ctl_fields_t);

endpackage

// File: rtl/lpi_rx_detect.sv
module lpi_rx_detect #(
  parameter int          CODE_W    = 8,
  parameter logic [7:0]  LPI_CODE  = 8'h01,
  parameter int          ENTRY_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_dv,
  input  logic              rx_er,
  input  logic [CODE_W-1:0] rxd,
  output logic              rx_live,
  output logic              enter_evt,
  output logic              exit_evt
);

  localparam int CNT_W = (ENTRY_LEN > 1) ? $clog2(ENTRY_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRY_LEN - 1);

  logic             match;
  logic [CNT_W-1:0] run_cnt;
  logic             live_q;

  assign match     = !rx_dv && rx_er && (rxd == CODE_W'(LPI_CODE));
  assign enter_evt = !live_q && match && (run_cnt == LAST);
  assign exit_evt  = live_q && !match;
  assign rx_live   = live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      live_q  <= 1'b0;
    end else if (live_q) begin
      run_cnt <= '0;
      if (!match) live_q <= 1'b0;
    end else if (match) begin
      if (run_cnt == LAST) begin
        live_q  <= 1'b1;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end else begin
      run_cnt <= '0;
    end
  end

endmodule

// File: rtl/lpi_evt_sticky.sv
module lpi_evt_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic         rd_clr,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (set_evt[i]) flags[i] <= 1'b1;
      else if (rd_clr)     flags[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/lpi_ctl_fields.sv
module lpi_ctl_fields
  import lpi_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  ctl_fields_t wr_val,
  input  logic        hw_clr_en,
  output ctl_fields_t ctl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else begin
      if (wr_en)     ctl        <= wr_val;
      if (hw_clr_en) ctl.lpi_en <= 1'b0;
    end
  end

endmodule

// File: rtl/lpi_ctl_stat_reg.sv
module lpi_ctl_stat_reg
  import lpi_csr_pkg::*;
#(
  parameter int         CODE_W    = 8,
  parameter logic [7:0] LPI_CODE  = 8'h01,
  parameter int         ENTRY_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  input  logic              rx_dv,
  input  logic              rx_er,
  input  logic [CODE_W-1:0] rxd,
  input  logic              tx_enter_pulse,
  input  logic              tx_exit_pulse,
  input  logic              tx_auto_exit,
  input  logic              tx_lpi_active,
  output logic              ctl_auto_mode,
  output logic              ctl_link_sel,
  output logic              ctl_link_up,
  output logic              ctl_lpi_en
);

  ctl_fields_t       ctl_q;
  ctl_fields_t       wr_val;
  logic              rx_live;
  logic              rx_enter;
  logic              rx_exit;
  logic              tx_live;
  logic [NUM_EVT-1:0] evt_set;
  logic [NUM_EVT-1:0] evt_bits;
  logic [WORD_W-1:0] image;
  logic              unused_wr_bits;

  assign wr_val = ctl_fields_t'(wr_data[POS_AUTO:POS_EN]);
  assign unused_wr_bits = ^{wr_data[WORD_W-1:POS_AUTO+1], wr_data[POS_EN-1:0]};

  lpi_ctl_fields u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_val    (wr_val),
    .hw_clr_en (tx_auto_exit),
    .ctl       (ctl_q)
  );

  lpi_rx_detect #(
    .CODE_W    (CODE_W),
    .LPI_CODE  (LPI_CODE),
    .ENTRY_LEN (ENTRY_LEN)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .rx_dv     (rx_dv),
    .rx_er     (rx_er),
    .rxd       (rxd),
    .rx_live   (rx_live),
    .enter_evt (rx_enter),
    .exit_evt  (rx_exit)
  );

  always_comb begin
    evt_set               = '0;
    evt_set[EVT_TX_ENTER] = tx_enter_pulse;
    evt_set[EVT_TX_EXIT]  = tx_exit_pulse;
    evt_set[EVT_RX_ENTER] = rx_enter;
    evt_set[EVT_RX_EXIT]  = rx_exit;
  end

  lpi_evt_sticky #(.N(NUM_EVT)) u_evt (
    .clk     (clk),
    .rst     (rst),
    .set_evt (evt_set),
    .rd_clr  (rd_en),
    .flags   (evt_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_live <= 1'b0;
    else     tx_live <= tx_lpi_active;
  end

  always_comb begin
    image                   = '0;
    image[POS_AUTO:POS_EN]  = ctl_q;
    image[POS_RX_LIVE]      = rx_live;
    image[POS_TX_LIVE]      = tx_live;
    image[NUM_EVT-1:0]      = evt_bits;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= image;
  end

  assign ctl_auto_mode = ctl_q.auto_mode;
  assign ctl_link_sel  = ctl_q.link_sel;
  assign ctl_link_up   = ctl_q.link_up;
  assign ctl_lpi_en    = ctl_q.lpi_en;

endmodule

// File: rtl/lpi_csr_checker.sv
module lpi_csr_checker (
  input logic        clk,
  input logic        rst,
  input logic        rd_en,
  input logic [31:0] rd_data,
  input logic        tx_enter_pulse,
  input logic        tx_auto_exit,
  input logic        ctl_lpi_en,
  input logic        rx_live,
  input logic [3:0]  evt_bits
);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data[31:20] == 12'h0) && (rd_data[15:10] == 6'h0) && (rd_data[7:4] == 4'h0));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !tx_enter_pulse) |=> !evt_bits[0]);

  assert_event_beats_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && tx_enter_pulse) |=> evt_bits[0]);

  assert_auto_exit_clears_R7: assert property (@(posedge clk) disable iff (rst)
    tx_auto_exit |=> !ctl_lpi_en);

  assert_rx_entry_flag_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_live) |-> evt_bits[2]);

  assert_rx_exit_flag_R13: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_live) |-> evt_bits[3]);

endmodule

bind lpi_ctl_stat_reg lpi_csr_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .rd_en          (rd_en),
  .rd_data        (rd_data),
  .tx_enter_pulse (tx_enter_pulse),
  .tx_auto_exit   (tx_auto_exit),
  .ctl_lpi_en     (ctl_lpi_en),
  .rx_live        (rx_live),
  .evt_bits       (evt_bits)
);

// File: tb/sim_lpi_ctl_stat_reg.sv
module sim_lpi_ctl_stat_reg;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [31:0] wr_data, rd_data;
  logic        rx_dv, rx_er;
  logic [7:0]  rxd;
  logic        tx_enter_pulse, tx_exit_pulse, tx_auto_exit, tx_lpi_active;
  logic        ctl_auto_mode, ctl_link_sel, ctl_link_up, ctl_lpi_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  lpi_ctl_stat_reg u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
    .tx_enter_pulse(tx_enter_pulse), .tx_exit_pulse(tx_exit_pulse),
    .tx_auto_exit(tx_auto_exit), .tx_lpi_active(tx_lpi_active),
    .ctl_auto_mode(ctl_auto_mode), .ctl_link_sel(ctl_link_sel),
    .ctl_link_up(ctl_link_up), .ctl_lpi_en(ctl_lpi_en)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(output logic [31:0] v);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rx_idle();
    rx_dv = 1'b0; rx_er = 1'b0; rxd = 8'h00;
  endtask

  // Drive one run, then two reads: the first sees live+entry, the second sees exit.
  task automatic rx_run(logic dv, logic er, logic [7:0] d, int len, string tag);
    logic [31:0] v1, v2;
    bit enter;
    enter = (dv == 1'b0) && (er == 1'b1) && (d == 8'h01) && (len >= 3);
    rx_dv = dv; rx_er = er; rxd = d;
    step(len);
    rx_idle();
    rd(v1);
    rd(v2);
    chk({tag, " first read"},  v1, enter ? 32'h0000_0204 : 32'h0);
    chk({tag, " second read"}, v2, enter ? 32'h0000_0008 : 32'h0);
    step(1);
  endtask

  initial begin
    logic [31:0] v;
    logic [7:0] codes [4];
    codes[0] = 8'h01; codes[1] = 8'h00; codes[2] = 8'h02; codes[3] = 8'hFF;
    rst = 1'b1; wr_en = 0; rd_en = 0; wr_data = '0;
    tx_enter_pulse = 0; tx_exit_pulse = 0; tx_auto_exit = 0; tx_lpi_active = 0;
    rx_idle();
    step(3);
    rst = 1'b0;
    step(1);

    // R1 reset state
    chk("R1 ctl ports", {28'h0, ctl_auto_mode, ctl_link_sel, ctl_link_up, ctl_lpi_en}, 32'h0);
    rd(v);
    chk("R1 word", v, 32'h0);

    // R2, R3: every control value, all other bits written as one
    for (int c = 0; c < 16; c++) begin
      wr({12'hFFF, c[3:0], 16'hFFFF});
      chk("R2 ctl ports", {28'h0, ctl_auto_mode, ctl_link_sel, ctl_link_up, ctl_lpi_en}, 32'(c));
      rd(v);
      chk("R2 R3 readback", v, 32'(c) << 16);
    end
    wr(32'h0);

    // R4, R5 transmit entry and exit flags
    tx_enter_pulse = 1; step(1); tx_enter_pulse = 0; step(2);
    rd(v); chk("R4 tx enter set", v, 32'h1);
    rd(v); chk("R5 tx enter cleared", v, 32'h0);
    tx_exit_pulse = 1; step(1); tx_exit_pulse = 0; step(2);
    rd(v); chk("R4 tx exit set", v, 32'h2);
    rd(v); chk("R5 tx exit cleared", v, 32'h0);

    // R6 event and read on one edge, flag already set
    tx_exit_pulse = 1; step(1); tx_exit_pulse = 0;
    rd_en = 1; tx_exit_pulse = 1; step(1); rd_en = 0; tx_exit_pulse = 0;
    chk("R6 read old (set)", rd_data, 32'h2);
    rd(v); chk("R6 kept set", v, 32'h2);
    rd(v); chk("R6 then cleared", v, 32'h0);
    // R6 flag clear beforehand
    rd_en = 1; tx_enter_pulse = 1; step(1); rd_en = 0; tx_enter_pulse = 0;
    chk("R6 read old (clear)", rd_data, 32'h0);
    rd(v); chk("R6 set after", v, 32'h1);
    rd(v); chk("R6 cleared after", v, 32'h0);

    // R7 automatic exit
    wr(32'h000F_0000);
    tx_auto_exit = 1; step(1); tx_auto_exit = 0;
    chk("R7 enable port", {31'h0, ctl_lpi_en}, 32'h0);
    rd(v); chk("R7 word", v, 32'h000E_0000);

    // R8 write and automatic exit together
    wr(32'h0);
    wr_en = 1; wr_data = 32'h000B_0000; tx_auto_exit = 1;
    step(1);
    wr_en = 0; wr_data = '0; tx_auto_exit = 0;
    rd(v); chk("R8 word", v, 32'h000A_0000);
    wr(32'h0);

    // R9 transmit live status
    tx_lpi_active = 1; step(1);
    tx_lpi_active = 0;
    rd(v); chk("R9 live high", v, 32'h0000_0100);
    rd(v); chk("R9 live low", v, 32'h0);

    // R10 pattern sweep, run of four
    for (int dv = 0; dv < 2; dv++)
      for (int er = 0; er < 2; er++)
        for (int k = 0; k < 4; k++)
          rx_run(dv[0], er[0], codes[k], 4, "R10 pattern");

    // R11, R12, R13 run lengths
    for (int len = 1; len <= 6; len++)
      rx_run(1'b0, 1'b1, 8'h01, len, (len < 3) ? "R12 short run" : "R11 R13 run");

    // R12 two short runs split by one idle cycle
    rx_dv = 0; rx_er = 1; rxd = 8'h01; step(2);
    rx_idle(); step(1);
    rx_dv = 0; rx_er = 1; rxd = 8'h01; step(2);
    rx_idle();
    rd(v); chk("R12 split runs", v, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule